// File: doc/BRIEF.md
# Serial NOR Flash Identity Probe

This block runs once after power-up, or whenever software pulses `start`, to find out which serial NOR flash sits on an SPI byte-exchange port. It first polls the device's status register until the write-in-progress flag is clear. It then sends the standard identification command and collects three reply bytes: manufacturer, memory type and capacity code. Each exchange moves one byte through a start/done handshake, and the block drives a separate active-low chip select that frames every command.

The manufacturer and memory type are checked against fixed accepted sets. The capacity code becomes a count of 4 KiB erase sectors. When the sequence ends the block raises `probe_done` and reports `id_valid` and `sector_count`. These results hold until the next accepted start. The serializer that moves the bits is outside the block.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is held, and after it is released with no start, `cs_n` is 1, `xfer_go` is 0, `probe_done` is 0, `id_valid` is 0 and `sector_count` is 0.
- R2: After an accepted start, the block sends a status frame made of command byte 0x05 and then filler 0xA5. It repeats this frame for as long as bit 0 of the byte returned during the filler is 1. The ID command is sent only after a status reply whose bit 0 is 0. The other bits of the status reply have no effect.
- R3: The ID frame keeps `cs_n` low without a break while it sends command 0x9F and three 0xA5 fillers. `cs_n` goes high after the frame. It is also high for at least one cycle between any two frames, and it is low whenever `xfer_go` is 1.
- R4: The manufacturer is the byte returned during the first ID filler. Only 0xEF and 0x37 are accepted.
- R5: The memory type is the byte returned during the second ID filler. Only 0x30, 0x40, 0x50, 0x60 and 0x70 are accepted.
- R6: The capacity code is the byte returned during the third ID filler. Codes 0x14, 0x15, 0x16, 0x17 and 0x18 give sector counts of 256, 512, 1024, 2048 and 4096.
- R7: If the manufacturer, the memory type or the capacity code is not accepted, the probe ends with `id_valid` = 0 and `sector_count` = 0.
- R8: `probe_done` rises in the cycle after the `xfer_done` of the third ID filler. From then on, `probe_done`, `id_valid` and `sector_count` keep their values until an accepted start, which clears `probe_done` in the next cycle.
- R9: A `start` pulse that arrives while a probe is running is ignored. The running sequence neither restarts nor sends extra frames.
- R10: `xfer_go` is a one-cycle pulse. No second `xfer_go` is raised until the `xfer_done` for the previous byte has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| xfer_go | output | 1 | Starts one byte exchange on the SPI port |
| xfer_tx | output | 8 | Byte to send during the exchange |
| xfer_done | input | 1 | One-cycle pulse when the exchange finishes |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| cs_n | output | 1 | Active-low flash chip select |
| probe_done | output | 1 | Probe finished; held until next accepted start |
| id_valid | output | 1 | Identity and capacity accepted |
| sector_count | output | 13 | Number of 4 KiB sectors, 0 when not valid |

## Verification
The hardest state to reach from the ports is a long busy period: a device that reports busy across several status frames. In that state only bit 0 may steer the sequence, and the chip select must be released between polls. The bench models a flash responder that keeps bit 0 set for a chosen number of status reads and also sets bit 1 in every reply. It then counts status frames and ID frames for each run. The same runs inject a stray `start` partway through polling and vary the handshake latency, so that a restart or a lost byte would show up as a wrong frame count.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam int BYTE_W        = 8;
  localparam int BUSY_BIT      = 0;
  localparam logic [BYTE_W-1:0] CMD_STATUS = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_IDENT  = 8'h9F;
  localparam logic [BYTE_W-1:0] FILLER     = 8'hA5;

  localparam int N_MFR  = 2;
  localparam int N_TYPE = 5;
  localparam logic [BYTE_W-1:0] MFR_CODES  [N_MFR]  = '{8'hEF, 8'h37};
  localparam logic [BYTE_W-1:0] TYPE_CODES [N_TYPE] = '{8'h30, 8'h40, 8'h50, 8'h60, 8'h70};

  // capacity code CAP_BASE+k means 2**(SECT_LOG_BASE+k) sectors
  localparam int CAP_BASE      = 'h14;
  localparam int CAP_STEPS     = 5;
  localparam int SECT_LOG_BASE = 8;
  localparam int CNT_W         = SECT_LOG_BASE + CAP_STEPS;

  typedef enum logic [2:0] {
    PH_IDLE, PH_STAT_CMD, PH_STAT_RD, PH_GAP,
    PH_ID_CMD, PH_ID_B0, PH_ID_B1, PH_ID_B2
  } phase_e;
endpackage

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_id_pkg::*;
(
  input  logic [BYTE_W-1:0] mfr,
  input  logic [BYTE_W-1:0] mtype,
  input  logic [BYTE_W-1:0] cap,
  output logic              ok,
  output logic [CNT_W-1:0]  count
);
  logic             mfr_hit;
  logic             type_hit;
  logic [CNT_W-1:0] cnt_v;

  always_comb begin
    mfr_hit  = 1'b0;
    type_hit = 1'b0;
    cnt_v    = '0;
    for (int i = 0; i < N_MFR; i++)
      if (mfr == MFR_CODES[i]) mfr_hit = 1'b1;
    for (int j = 0; j < N_TYPE; j++)
      if (mtype == TYPE_CODES[j]) type_hit = 1'b1;
    for (int k = 0; k < CAP_STEPS; k++)
      if (cap == BYTE_W'(CAP_BASE + k)) cnt_v[SECT_LOG_BASE + k] = 1'b1;
    ok    = mfr_hit && type_hit && (|cnt_v);
    count = ok ? cnt_v : '0;
  end
endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq
  import flash_id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              launch,
  output logic              fin,
  output logic              xfer_go,
  output logic [BYTE_W-1:0] xfer_tx,
  input  logic              xfer_done,
  input  logic [BYTE_W-1:0] xfer_rx,
  output logic              cs_n,
  output logic [BYTE_W-1:0] mfr_q,
  output logic [BYTE_W-1:0] type_q
);
  phase_e            phase, phase_n;
  logic              issued, issued_n;
  logic              to_id, to_id_n;
  logic [BYTE_W-1:0] mfr_n, type_n;
  logic              byte_ph;

  assign byte_ph = (phase != PH_IDLE) && (phase != PH_GAP);
  assign xfer_go = byte_ph && !issued;
  assign cs_n    = !byte_ph;

  always_comb begin
    unique case (phase)
      PH_STAT_CMD: xfer_tx = CMD_STATUS;
      PH_ID_CMD:   xfer_tx = CMD_IDENT;
      default:     xfer_tx = FILLER;
    endcase
  end

  always_comb begin
    phase_n  = phase;
    issued_n = issued;
    to_id_n  = to_id;
    mfr_n    = mfr_q;
    type_n   = type_q;
    launch   = 1'b0;
    fin      = 1'b0;
    if (phase == PH_IDLE) begin
      if (start) begin
        phase_n  = PH_STAT_CMD;
        issued_n = 1'b0;
        launch   = 1'b1;
      end
    end else if (phase == PH_GAP) begin
      phase_n = to_id ? PH_ID_CMD : PH_STAT_CMD;
    end else if (!issued) begin
      issued_n = 1'b1;
    end else if (xfer_done) begin
      issued_n = 1'b0;
      unique case (phase)
        PH_STAT_CMD: phase_n = PH_STAT_RD;
        PH_STAT_RD: begin
          phase_n = PH_GAP;
          to_id_n = !xfer_rx[BUSY_BIT];
        end
        PH_ID_CMD: phase_n = PH_ID_B0;
        PH_ID_B0: begin
          mfr_n   = xfer_rx;
          phase_n = PH_ID_B1;
        end
        PH_ID_B1: begin
          type_n  = xfer_rx;
          phase_n = PH_ID_B2;
        end
        default: begin
          fin     = 1'b1;
          phase_n = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      issued <= 1'b0;
      to_id  <= 1'b0;
      mfr_q  <= '0;
      type_q <= '0;
    end else begin
      phase  <= phase_n;
      issued <= issued_n;
      to_id  <= to_id_n;
      mfr_q  <= mfr_n;
      type_q <= type_n;
    end
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              xfer_go,
  output logic [BYTE_W-1:0] xfer_tx,
  input  logic              xfer_done,
  input  logic [BYTE_W-1:0] xfer_rx,
  output logic              cs_n,
  output logic              probe_done,
  output logic              id_valid,
  output logic [CNT_W-1:0]  sector_count
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_i_n;
  logic                   launch, fin, dec_ok;
  logic [BYTE_W-1:0]      mfr_q, type_q;
  logic [CNT_W-1:0]       dec_cnt;
  logic                   done_n, valid_n;
  logic [CNT_W-1:0]       count_n;
  logic                   res_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe[SYNC_STAGES-1];

  flash_id_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .launch(launch), .fin(fin),
    .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx), .cs_n(cs_n), .mfr_q(mfr_q), .type_q(type_q)
  );

  flash_id_decode u_dec (
    .mfr(mfr_q), .mtype(type_q), .cap(xfer_rx), .ok(dec_ok), .count(dec_cnt)
  );

  assign res_en = launch || fin;

  always_comb begin
    done_n  = fin;
    valid_n = fin ? dec_ok : id_valid;
    count_n = fin ? dec_cnt : sector_count;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      probe_done   <= 1'b0;
      id_valid     <= 1'b0;
      sector_count <= '0;
    end else if (res_en) begin
      probe_done   <= done_n;
      id_valid     <= valid_n;
      sector_count <= count_n;
    end
  end
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk
  import flash_id_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cs_n,
  input logic             xfer_go,
  input logic             xfer_done,
  input logic             probe_done,
  input logic             id_valid,
  input logic [CNT_W-1:0] sector_count
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (xfer_go)   pending <= 1'b1;
    else if (xfer_done) pending <= 1'b0;
  end

  // R10
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);
  // R10
  go_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !xfer_go);
  // R3
  go_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> !cs_n);
  // R3
  done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |-> cs_n);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_done && !start) |=> (probe_done && $stable(id_valid) && $stable(sector_count)));
  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_done && !id_valid) |-> (sector_count == '0));
  // R6
  count_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sector_count));
endmodule

bind flash_id_probe flash_id_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .xfer_go(xfer_go),
  .xfer_done(xfer_done), .probe_done(probe_done), .id_valid(id_valid),
  .sector_count(sector_count)
);

// File: tb/flash_id_probe_test.sv
module flash_id_probe_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 13;

  logic          clk, rst_n, start;
  logic          xfer_go, xfer_done, cs_n;
  logic [7:0]    xfer_tx, xfer_rx;
  logic          probe_done, id_valid;
  logic [CW-1:0] sector_count;

  int checks, fails;
  // responder / model state
  logic [7:0] id_bytes [3];
  int busy_left, lat, cnt, idx, stat_frames, id_frames;
  logic [7:0] frame_cmd, resp;
  bit pend, pend_final, run_on, prev_cs_n;
  bit exp_done, exp_valid;
  logic [CW-1:0] exp_cnt;

  flash_id_probe uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n), .probe_done(probe_done),
    .id_valid(id_valid), .sector_count(sector_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_count(logic [7:0] m, logic [7:0] t, logic [7:0] c);
    bit okm, okt;
    okm = (m == 8'hEF) || (m == 8'h37);
    okt = (t == 8'h30) || (t == 8'h40) || (t == 8'h50) || (t == 8'h60) || (t == 8'h70);
    if (!(okm && okt)) return 0;
    case (c)
      8'h14: return 256;
      8'h15: return 512;
      8'h16: return 1024;
      8'h17: return 2048;
      8'h18: return 4096;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle-by-cycle model and flash responder, all on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(probe_done == exp_done, "R8 done", probe_done, exp_done);
      chk(id_valid == exp_valid, "R4/R5/R7 valid", id_valid, exp_valid);
      chk(sector_count == exp_cnt, "R6/R7 count", sector_count, exp_cnt);
      if (!run_on) chk(cs_n == 1'b1, "R3 idle cs", cs_n, 1);
      // R3: chip select may not rise inside a frame
      if (cs_n && !prev_cs_n && idx > 0) begin
        if (frame_cmd == 8'h9F) chk(idx == 4, "R3 id frame length", idx, 4);
        else chk(idx == 2, "R2 status frame length", idx, 2);
      end
      prev_cs_n = cs_n;
      if (cs_n) idx = 0;
      // done pulse generation
      xfer_done = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          xfer_done = 1'b1;
          xfer_rx = resp;
          pend = 1'b0;
          if (pend_final) begin
            pend_final = 1'b0;
            run_on = 1'b0;
            exp_done = 1'b1;
            exp_cnt = CW'(ref_count(id_bytes[0], id_bytes[1], id_bytes[2]));
            exp_valid = (exp_cnt != 0);
          end
        end else cnt--;
      end
      if (xfer_go) begin
        chk(!cs_n, "R3 go under cs", cs_n, 0);
        resp = 8'hFF;
        if (idx == 0) begin
          frame_cmd = xfer_tx;
          chk(xfer_tx == 8'h05 || xfer_tx == 8'h9F, "R2 command", xfer_tx, 8'h05);
          if (xfer_tx == 8'h05) stat_frames++;
          else id_frames++;
        end else begin
          chk(xfer_tx == 8'hA5, "R2/R3 filler", xfer_tx, 8'hA5);
          if (frame_cmd == 8'h05) begin
            // bit 1 always set: only bit 0 may matter
            resp = (busy_left > 0) ? 8'h03 : 8'h02;
            if (busy_left > 0) busy_left--;
          end else if (idx <= 3) begin
            resp = id_bytes[idx-1];
            if (idx == 3) pend_final = 1'b1;
          end
        end
        idx++;
        pend = 1'b1;
        cnt = lat;
      end
      if (start && !run_on) begin
        run_on = 1'b1;
        exp_done = 1'b0;
      end
    end
  end

  task automatic run_probe(logic [7:0] m, logic [7:0] t, logic [7:0] c,
                           int busy, int l, bit stray_start, string tag);
    int polls;
    id_bytes[0] = m; id_bytes[1] = t; id_bytes[2] = c;
    busy_left = busy; lat = l; stat_frames = 0; id_frames = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (stray_start) begin
      repeat (6) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (!exp_done) @(posedge clk);
    repeat (4) @(posedge clk);
    polls = busy + 1;
    chk(stat_frames == polls, {tag, " R2 status polls"}, stat_frames, polls);
    chk(id_frames == 1, {tag, " R3/R9 id frames"}, id_frames, 1);
  endtask

  initial begin
    checks = 0; fails = 0;
    start = 0; xfer_done = 0; xfer_rx = 0; rst_n = 0;
    pend = 0; pend_final = 0; run_on = 0; prev_cs_n = 1; idx = 0;
    exp_done = 0; exp_valid = 0; exp_cnt = '0; lat = 0; busy_left = 0;
    frame_cmd = 0; resp = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n && !xfer_go && !probe_done && !id_valid && sector_count == 0,
        "R1 reset", {cs_n, xfer_go, probe_done, id_valid}, 4'b1000);
    @(posedge clk); #1 rst_n = 1;
    repeat (5) @(posedge clk);
    #1 chk(cs_n && !xfer_go && !probe_done, "R1 after release", {cs_n, xfer_go, probe_done}, 3'b100);
    run_probe(8'hEF, 8'h40, 8'h18, 2, 0, 0, "R6 4096");
    run_probe(8'h37, 8'h30, 8'h14, 0, 2, 0, "R4 second mfr 256");
    run_probe(8'hEF, 8'h60, 8'h15, 3, 1, 1, "R9 stray start 512");
    run_probe(8'hEF, 8'h50, 8'h16, 0, 0, 0, "R5 1024");
    run_probe(8'h37, 8'h70, 8'h17, 1, 3, 0, "R6 2048");
    run_probe(8'hC2, 8'h40, 8'h17, 0, 0, 0, "R4 bad mfr");
    run_probe(8'hEF, 8'h20, 8'h16, 0, 1, 0, "R5 bad type");
    run_probe(8'hEF, 8'h40, 8'h19, 1, 0, 0, "R7 bad capacity");
    run_probe(8'hEF, 8'h40, 8'h13, 0, 0, 0, "R7 low capacity");
    run_probe(8'h37, 8'h60, 8'h18, 5, 4, 1, "R10 slow 4096");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule